// File: doc/BRIEF.md
# I/O Delay Tap Calibration Controller

This block steers a tapped delay line of up to 256 steps that sits on a data pin. The delay cells live outside the block. The controller drives them through three single-cycle commands: step up, step down and return to zero. It also keeps a registered copy of the tap value those commands produce. At reset the tap value is a static startup setting. It can later be moved one step at a time while the pin is in use.

A calibration request starts a measurement. The controller returns the line to tap zero and then climbs one tap per cycle until an external period-match detector reports that the delay covers one full I/O clock period. It then walks the delay back down to half of the measured count, which puts the sampling clock in the middle of the data eye. The busy flag stays high from the request until that half value is in place. If the top tap is reached with no match, the measurement saturates there and an overflow flag is set.

When the controller is not busy, it tracks drift on differential inputs. A phase detector reports early or late sampling, and the controller counts votes that agree in direction. After a programmable number of such votes it moves the delay by exactly one tap, and it never wraps past either end of the range. One tap value serves both the input and the output direction of a bidirectional pin. A registered route flag follows the pin's drive enable, so turning the pin around does not disturb the delay.

Top module: `iodly_cal_ctrl`

## Requirements
- R1: During and after reset, `tap_val` equals the INIT_TAP parameter (default 16). `busy`, `cal_ovf`, `route_out` and all three delay commands are 0.
- R2: A `cal_req` sampled high while idle produces the following at the next edge: `tap_val` = 0, a one-cycle `dly_rst` pulse, `busy` = 1 and `cal_ovf` cleared.
- R3: While measuring, each edge at which `per_match` is low and the tap is below 255 raises `tap_val` by one and pulses `dly_inc`.
- R4: When `per_match` is seen high at tap T during the measurement, the tap is stepped down one per cycle, each step with a `dly_dec` pulse, to floor(T/2). `busy` falls at the edge after the tap equals that value.
- R5: If the measurement reaches tap 255 without a match, `cal_ovf` is set to 1 and the result loaded is 127.
- R6: While `busy` is high, the `pd_early`/`pd_late` inputs and further `cal_req` pulses have no effect, and the vote count is cleared.
- R7: When idle, `pd_early` alone is an up vote, `pd_late` alone is a down vote, and both high or both low is no vote. A vote in the opposite direction restarts the count at 1. When the count of consecutive same-direction votes reaches `vote_need`, the tap moves by one (up with `dly_inc`, down with `dly_dec`) and the count clears. A `vote_need` of 0 acts as 1.
- R8: An up step at tap 255 or a down step at tap 0 leaves the tap unchanged and emits no command pulse.
- R9: At most one of `dly_inc`, `dly_dec` and `dly_rst` is high in any cycle. `tap_val` changes only together with one of them.
- R10: `route_out` equals `drive_en` delayed by one cycle, and toggling `drive_en` never changes `tap_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | Start a period measurement and half-load |
| per_match | input | 1 | High when the current delay spans one full I/O clock period |
| pd_early | input | 1 | Phase detector: sampling early (up vote) |
| pd_late | input | 1 | Phase detector: sampling late (down vote) |
| vote_need | input | VOTE_W | Agreeing votes required per tracking step (0 treated as 1) |
| drive_en | input | 1 | Pin direction: 1 = output |
| dly_inc | output | 1 | One-cycle command: delay line up one tap |
| dly_dec | output | 1 | One-cycle command: delay line down one tap |
| dly_rst | output | 1 | One-cycle command: delay line to tap zero |
| tap_val | output | TAP_W | Current tap value |
| busy | output | 1 | Calibration in progress |
| cal_ovf | output | 1 | Last measurement found no match below the top tap |
| route_out | output | 1 | Registered direction that the shared delay value follows |

## Verification
The bench measures periods of 40, 7, 0 and more than 255 taps. These cover the odd-count floor, a match on the very first tap, and the overflow path. A design that rounds up would land one tap high, one that checks the top before the match would flag overflow wrongly, and one that drops `busy` early would let tracking disturb the result. Tracking is driven with alternating votes, simultaneous early/late, and runs long enough to push against both range ends. A controller that fails to restart its count, or that wraps from 255 to 0, shows up as an unexpected tap change or a command pulse. Phase-detector votes and repeat requests are held on throughout a calibration, so a controller that does not ignore them lands off the half value.

// File: rtl/iodly_pkg.sv
package iodly_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_SCAN = 2'd1,
    CAL_DOWN = 2'd2
  } cal_st_e;
endpackage

// File: rtl/iodly_tap_reg.sv
// Saturating tap register that mirrors the external delay line and
// issues the matching one-cycle command for every change.
module iodly_tap_reg #(
  parameter int TAP_W    = 8,
  parameter int INIT_TAP = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_zero,
  input  logic             inc,
  input  logic             dec,
  output logic [TAP_W-1:0] tap,
  output logic             p_inc,
  output logic             p_dec,
  output logic             p_rst,
  output logic             at_max,
  output logic             at_min
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  assign at_max = (tap == TAP_MAX);
  assign at_min = (tap == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tap   <= TAP_W'(INIT_TAP);
      p_inc <= 1'b0;
      p_dec <= 1'b0;
      p_rst <= 1'b0;
    end else begin
      p_inc <= 1'b0;
      p_dec <= 1'b0;
      p_rst <= 1'b0;
      if (ld_zero) begin
        tap   <= '0;
        p_rst <= 1'b1;
      end else if (inc && !at_max) begin
        tap   <= tap + 1'b1;
        p_inc <= 1'b1;
      end else if (dec && !at_min) begin
        tap   <= tap - 1'b1;
        p_dec <= 1'b1;
      end
    end
  end

  p_one_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({p_inc, p_dec, p_rst}));
  p_inc_step_r3: assert property (@(posedge clk) disable iff (rst)
    p_inc |-> tap == TAP_W'($past(tap) + 1'b1));
  p_dec_step_r4: assert property (@(posedge clk) disable iff (rst)
    p_dec |-> tap == TAP_W'($past(tap) - 1'b1));
  p_rst_zero_r2: assert property (@(posedge clk) disable iff (rst)
    p_rst |-> tap == '0);
  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(p_inc || p_dec || p_rst) |-> $stable(tap));
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (at_max && !ld_zero) |=> !p_rst && tap != '0);
endmodule

// File: rtl/iodly_vote.sv
// Phase-detector vote accumulator: emits a one-cycle step request once
// enough consecutive votes agree in direction.
module iodly_vote #(
  parameter int VOTE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              early,
  input  logic              late,
  input  logic [VOTE_W-1:0] need,
  output logic              up_req,
  output logic              dn_req
);
  logic [VOTE_W:0] cnt_q, nxt_cnt, need_eff;
  logic            dir_up_q;
  logic            valid, vote_up, same, fire;

  always_comb begin
    valid    = early ^ late;
    vote_up  = early;
    same     = (cnt_q != '0) && (dir_up_q == vote_up);
    nxt_cnt  = same ? cnt_q + 1'b1 : (VOTE_W+1)'(1);
    need_eff = (need == '0) ? (VOTE_W+1)'(1) : {1'b0, need};
    fire     = valid && !clr && (nxt_cnt >= need_eff);
    up_req   = fire && vote_up;
    dn_req   = fire && !vote_up;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b0;
    end else if (valid) begin
      cnt_q    <= fire ? '0 : nxt_cnt;
      dir_up_q <= vote_up;
    end
  end

  p_clr_drops_votes_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == '0);
  p_up_from_early_r7: assert property (@(posedge clk) disable iff (rst)
    up_req |-> (early && !late && !clr));
  p_dn_from_late_r7: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> (late && !early && !clr));
endmodule

// File: rtl/iodly_cal_fsm.sv
// Measurement sequencer: zero, climb to the period match, walk down
// to half the measured count.
module iodly_cal_fsm
  import iodly_pkg::*;
#(
  parameter int TAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_req,
  input  logic             per_match,
  input  logic [TAP_W-1:0] tap,
  input  logic             at_max,
  output logic             busy,
  output logic             ovf,
  output logic             cal_start,
  output logic             inc_req,
  output logic             dec_req
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  cal_st_e          st_q;
  logic [TAP_W-1:0] tgt_q;

  assign cal_start = (st_q == CAL_IDLE) && cal_req;
  assign inc_req   = (st_q == CAL_SCAN) && !per_match && !at_max;
  assign dec_req   = (st_q == CAL_DOWN) && (tap != tgt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= CAL_IDLE;
      tgt_q <= '0;
      busy  <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      case (st_q)
        CAL_IDLE: if (cal_req) begin
          st_q <= CAL_SCAN;
          busy <= 1'b1;
          ovf  <= 1'b0;
        end
        CAL_SCAN: if (per_match) begin
          tgt_q <= tap >> 1;
          st_q  <= CAL_DOWN;
        end else if (at_max) begin
          tgt_q <= tap >> 1;
          ovf   <= 1'b1;
          st_q  <= CAL_DOWN;
        end
        CAL_DOWN: if (tap == tgt_q) begin
          busy <= 1'b0;
          st_q <= CAL_IDLE;
        end
        default: st_q <= CAL_IDLE;
      endcase
    end
  end

  p_ovf_at_top_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> tap == TAP_MAX);
  p_done_at_half_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> tap == tgt_q);
  p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> busy && !ovf);
endmodule

// File: rtl/iodly_cal_ctrl.sv
module iodly_cal_ctrl #(
  parameter int TAP_W    = 8,
  parameter int VOTE_W   = 4,
  parameter int INIT_TAP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_req,
  input  logic              per_match,
  input  logic              pd_early,
  input  logic              pd_late,
  input  logic [VOTE_W-1:0] vote_need,
  input  logic              drive_en,
  output logic              dly_inc,
  output logic              dly_dec,
  output logic              dly_rst,
  output logic [TAP_W-1:0]  tap_val,
  output logic              busy,
  output logic              cal_ovf,
  output logic              route_out
);
  logic cal_start, fsm_inc, fsm_dec, trk_up, trk_dn;
  logic at_max, at_min, hold_trk;

  assign hold_trk = busy || cal_start;

  iodly_cal_fsm #(.TAP_W(TAP_W)) u_fsm (
    .clk(clk), .rst(rst), .cal_req(cal_req), .per_match(per_match),
    .tap(tap_val), .at_max(at_max), .busy(busy), .ovf(cal_ovf),
    .cal_start(cal_start), .inc_req(fsm_inc), .dec_req(fsm_dec)
  );

  iodly_vote #(.VOTE_W(VOTE_W)) u_vote (
    .clk(clk), .rst(rst), .clr(hold_trk), .early(pd_early), .late(pd_late),
    .need(vote_need), .up_req(trk_up), .dn_req(trk_dn)
  );

  iodly_tap_reg #(.TAP_W(TAP_W), .INIT_TAP(INIT_TAP)) u_tap (
    .clk(clk), .rst(rst), .ld_zero(cal_start),
    .inc(fsm_inc || (trk_up && !hold_trk)),
    .dec(fsm_dec || (trk_dn && !hold_trk)),
    .tap(tap_val), .p_inc(dly_inc), .p_dec(dly_dec), .p_rst(dly_rst),
    .at_max(at_max), .at_min(at_min)
  );

  always_ff @(posedge clk) begin
    if (rst) route_out <= 1'b0;
    else     route_out <= drive_en;
  end

  p_route_follows_r10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> route_out == $past(drive_en));
  p_busy_no_track_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !(fsm_inc || fsm_dec)) |=> !dly_inc && !dly_dec && !dly_rst);
endmodule

// File: tb/tb_iodly_cal_ctrl.sv
module tb_iodly_cal_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_TAP   = 16;

  logic       clk = 1'b0;
  logic       rst, cal_req, pd_early, pd_late, drive_en;
  logic [3:0] vote_need;
  logic       per_match;
  logic       dly_inc, dly_dec, dly_rst, busy, cal_ovf, route_out;
  logic [7:0] tap_val;
  int         per_taps;

  int vectors = 0, miscompares = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  int m_tap, m_mode, m_tgt, m_vcnt, m_vdir;
  bit m_busy, m_ovf, m_inc, m_dec, m_rst, m_route;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign per_match = (int'(tap_val) >= per_taps);

  iodly_cal_ctrl #(.INIT_TAP(INIT_TAP)) dut (
    .clk(clk), .rst(rst), .cal_req(cal_req), .per_match(per_match),
    .pd_early(pd_early), .pd_late(pd_late), .vote_need(vote_need),
    .drive_en(drive_en), .dly_inc(dly_inc), .dly_dec(dly_dec),
    .dly_rst(dly_rst), .tap_val(tap_val), .busy(busy), .cal_ovf(cal_ovf),
    .route_out(route_out)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_tap = INIT_TAP; m_mode = 0; m_tgt = 0; m_vcnt = 0; m_vdir = 0;
      m_busy = 0; m_ovf = 0; m_inc = 0; m_dec = 0; m_rst = 0; m_route = 0;
    end else begin
      m_inc = 0; m_dec = 0; m_rst = 0;
      m_route = drive_en;
      if (m_mode == 0) begin
        if (cal_req) begin
          m_tap = 0; m_rst = 1; m_busy = 1; m_ovf = 0; m_mode = 1; m_vcnt = 0;
        end else if (pd_early != pd_late) begin
          int d, need;
          d = pd_early ? 1 : -1;
          if (m_vcnt > 0 && m_vdir == d) m_vcnt++;
          else begin m_vdir = d; m_vcnt = 1; end
          need = (vote_need == 0) ? 1 : int'(vote_need);
          if (m_vcnt >= need) begin
            m_vcnt = 0;
            if (d == 1 && m_tap < 255) begin m_tap++; m_inc = 1; end
            if (d == -1 && m_tap > 0) begin m_tap--; m_dec = 1; end
          end
        end
      end else if (m_mode == 1) begin
        if (m_tap >= per_taps) begin m_tgt = m_tap / 2; m_mode = 2; end
        else if (m_tap == 255) begin m_ovf = 1; m_tgt = 127; m_mode = 2; end
        else begin m_tap++; m_inc = 1; end
      end else begin
        if (m_tap == m_tgt) begin m_busy = 0; m_mode = 0; end
        else begin m_tap--; m_dec = 1; end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    vectors++;
    if (int'(tap_val) != m_tap || busy != m_busy || cal_ovf != m_ovf ||
        dly_inc != m_inc || dly_dec != m_dec || dly_rst != m_rst ||
        route_out != m_route) begin
      miscompares++;
      $display("FAIL %s cyc %0d: tap/busy/ovf/inc/dec/rst/route act %0d/%0b/%0b/%0b/%0b/%0b/%0b exp %0d/%0b/%0b/%0b/%0b/%0b/%0b",
        cur_req, cyc, tap_val, busy, cal_ovf, dly_inc, dly_dec, dly_rst, route_out,
        m_tap, m_busy, m_ovf, m_inc, m_dec, m_rst, m_route);
    end
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: act %0d cycles exp at most 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic calibrate(input int per);
    per_taps = per;
    cal_req = 1'b1;
    cycles(1);
    cal_req = 1'b0;
    check("R2 busy at start", int'(busy), 1);
    check("R2 tap zeroed", int'(tap_val), 0);
    check("R2 reset pulse", int'(dly_rst), 1);
    wait_idle();
  endtask

  task automatic votes(input bit e, input bit l, input int n);
    for (int i = 0; i < n; i++) begin
      pd_early = e; pd_late = l; drive_en = ~drive_en;
      cycles(1);
    end
    pd_early = 0; pd_late = 0;
  endtask

  initial begin
    rst = 1; cal_req = 0; pd_early = 0; pd_late = 0; drive_en = 0;
    vote_need = 4'd3; per_taps = 1000;
    cycles(3);
    check("R1 reset tap", int'(tap_val), INIT_TAP);
    check("R1 reset busy", int'(busy), 0);
    rst = 0;
    cycles(1);
    check("R1 tap after reset", int'(tap_val), INIT_TAP);

    cur_req = "R3";
    per_taps = 40;
    cal_req = 1'b1;
    cycles(1);
    cal_req = 1'b0;
    check("R2 tap zero", int'(tap_val), 0);
    check("R2 busy", int'(busy), 1);
    cycles(5);
    check("R3 climbing tap", int'(tap_val), 5);
    check("R3 inc pulse", int'(dly_inc), 1);
    cur_req = "R4";
    wait_idle();
    check("R4 half of 40", int'(tap_val), 20);
    check("R4 no overflow", int'(cal_ovf), 0);

    cur_req = "R4";
    calibrate(7);
    check("R4 floor of 7/2", int'(tap_val), 3);
    calibrate(0);
    check("R4 match at tap 0", int'(tap_val), 0);

    cur_req = "R6";
    per_taps = 40;
    cal_req = 1'b1;
    cycles(1);
    pd_early = 1'b1;
    vote_need = 4'd1;
    cycles(10);
    check("R6 busy during cal", int'(busy), 1);
    while (busy) @(negedge clk);
    pd_early = 1'b0;
    cal_req = 1'b0;
    check("R6 result unaffected by votes", int'(tap_val), 20);
    cycles(1);

    cur_req = "R7";
    vote_need = 4'd3;
    votes(1, 0, 3);
    check("R7 three up votes", int'(tap_val), 21);
    votes(1, 0, 1); votes(0, 1, 1); votes(1, 0, 1); votes(0, 1, 1);
    votes(1, 0, 2); votes(0, 1, 2);
    check("R7 alternating votes no step", int'(tap_val), 21);
    votes(1, 1, 6);
    check("R7 both high no vote", int'(tap_val), 21);
    votes(0, 1, 3);
    check("R7 three down votes", int'(tap_val), 20);

    cur_req = "R10";
    drive_en = 1'b1;
    cycles(1);
    check("R10 route follows", int'(route_out), 1);
    check("R10 tap kept", int'(tap_val), 20);
    drive_en = 1'b0;
    cycles(1);
    check("R10 route back", int'(route_out), 0);

    cur_req = "R5";
    calibrate(1000);
    check("R5 overflow flag", int'(cal_ovf), 1);
    check("R5 saturated half", int'(tap_val), 127);

    cur_req = "R8";
    vote_need = 4'd0;
    votes(1, 0, 140);
    check("R8 top saturation", int'(tap_val), 255);
    votes(1, 0, 1);
    check("R8 no inc at top", int'(dly_inc), 0);
    votes(0, 1, 270);
    check("R8 bottom saturation", int'(tap_val), 0);
    votes(0, 1, 1);
    check("R8 no dec at bottom", int'(dly_dec), 0);

    cur_req = "R9";
    calibrate(9);
    check("R9 final tap", int'(tap_val), 4);
    cycles(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule